// File: doc/BRIEF.md
# Channel-Status Block Start Generator

This block handles the marker that flags frame 0 of each channel-status block in a digital audio transmitter. A single bidirectional marker line can run in one of two directions. When the line is an input, an external source drives it and the block samples it on one edge of the frame sync. A high sample means a new block starts, and the block realigns its internal frame counter to that frame. When the line is an output, the block counts frame-sync edges and drives the line high for one frame period at the start of every block. A block is 192 frames in stereo and 384 in mono.

The frame-sync edge used for sampling and for toggling depends on a sync-phase setting. With phase 0, the input is sampled on rising edges and the output changes on falling edges. With phase 1, the two edges swap. In strap mode the phase comes from a two-bit format code and the software phase bit is not used. The frame sync and the incoming marker are both asynchronous, so each passes through a synchronizer before use. Edges are detected on the synchronized frame sync.

Top module: `blsgen_top`

## Requirements
- R1: With dirOut = 0 the marker is an input: blsOe is low and blsOut stays low. Out of reset blsOut and blockStart are low.
- R2: In input mode the effective phase picks the sampling edge: rising frame-sync edges for phase 0, falling edges for phase 1. A marker level present only at the other edge is never sampled.
- R3: A high input sample raises blockStart for exactly one clock cycle. A low sample raises nothing.
- R4: In output mode blsOut goes high at the 1st active edge after reset and at every 192nd active edge after that (every 384th when monoMode = 1). It returns low at the next active edge.
- R5: In output mode the active edge is the falling frame-sync edge for phase 0 and the rising edge for phase 1.
- R6: With strapMode = 1 the phase comes from strapFmt: code 2'b01 (the I2S layout) gives phase 1, and codes 2'b00, 2'b10 and 2'b11 give phase 0. syncPhase is ignored.
- R7: A sampled block start sets the frame counter so that the next frame is frame 1. This takes priority over the counter wrap in the same cycle. After a switch to output mode, the next pulse therefore comes exactly one block after the sampled start.
- R8: In output mode blockStart also pulses for one cycle each time blsOut rises.
- R9: A frame-sync change reaches blsOut and blockStart on the 3rd rising clock edge after it: two synchronizer stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Asynchronous audio frame sync |
| blsIn | input | 1 | Asynchronous incoming block-start marker |
| dirOut | input | 1 | 0 = marker is an input, 1 = marker is driven |
| monoMode | input | 1 | 1 = 384-edge block period, 0 = 192 |
| syncPhase | input | 1 | Software sync-phase bit |
| strapMode | input | 1 | 1 = phase taken from strapFmt |
| strapFmt | input | 2 | Strap format code, 2'b01 selects phase 1 |
| blsOut | output | 1 | Driven marker level |
| blsOe | output | 1 | Output enable for the marker pad |
| blockStart | output | 1 | One-cycle block-start strobe |

## Verification
Two things can land on the same frame-sync strobe: a sampled block start and the frame counter reaching its last index. The bench provokes this by running 191 input-mode frames with the marker low. It then drives the marker high on the next sampling edge, which is exactly the strobe where the counter would wrap. After that it switches to output mode and counts falling edges. If the realignment won, the first pulse appears on the 192nd falling edge and on no earlier one. If the wrap won, a pulse appears on the very first falling edge.

// File: rtl/blsgen_pkg.sv
package blsgen_pkg;
  // strap format code that selects the phase-1 (I2S) layout
  localparam logic [1:0] FMT_I2S = 2'b01;

  typedef struct packed {
    logic sampleEdge;  // input mode: sample the marker now
    logic toggleEdge;  // output mode: advance and update the marker now
    logic outMode;     // marker is driven
    logic monoMode;    // doubled block period
  } blsStrobe_t;
endpackage

// File: rtl/blsgen_ctrl.sv
module blsgen_ctrl
  import blsgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic       dirOut,
  input  logic       monoMode,
  input  logic       syncPhase,
  input  logic       strapMode,
  input  logic [1:0] strapFmt,
  output blsStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] fsChain;
  logic          fsPrev;
  logic          fsRise, fsFall, effPhase;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) fsChain <= '0;
        else       fsChain <= frameSync;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rstN) fsChain <= '0;
        else       fsChain <= {fsChain[LAST-1:0], frameSync};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) fsPrev <= 1'b0;
    else       fsPrev <= fsChain[LAST];
  end

  always_comb begin
    fsRise   = fsChain[LAST] & ~fsPrev;
    fsFall   = ~fsChain[LAST] & fsPrev;
    effPhase = strapMode ? (strapFmt == FMT_I2S) : syncPhase;
    strobe.sampleEdge = ~dirOut & (effPhase ? fsFall : fsRise);
    strobe.toggleEdge = dirOut & (effPhase ? fsRise : fsFall);
    strobe.outMode    = dirOut;
    strobe.monoMode   = monoMode;
  end
endmodule

// File: rtl/blsgen_datapath.sv
module blsgen_datapath
  import blsgen_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       blsIn,
  input  blsStrobe_t strobe,
  output logic       blsOut,
  output logic       blockStart
);
  localparam int CNT_W = $clog2(2 * FRAMES_PER_BLOCK);
  localparam logic [CNT_W-1:0] LAST_STEREO = CNT_W'(FRAMES_PER_BLOCK - 1);
  localparam logic [CNT_W-1:0] LAST_MONO   = CNT_W'(2 * FRAMES_PER_BLOCK - 1);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0]      inChain;
  logic [CNT_W-1:0]   frameCnt, cntNext, lastIdx;
  logic               pulseQ, startQ;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) inChain <= '0;
        else       inChain <= blsIn;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rstN) inChain <= '0;
        else       inChain <= {inChain[LAST-1:0], blsIn};
      end
    end
  endgenerate

  always_comb begin
    lastIdx = strobe.monoMode ? LAST_MONO : LAST_STEREO;
    cntNext = (frameCnt >= lastIdx) ? '0 : frameCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
      pulseQ   <= 1'b0;
      startQ   <= 1'b0;
    end else begin
      startQ <= 1'b0;
      if (!strobe.outMode) pulseQ <= 1'b0;
      if (strobe.sampleEdge) begin
        if (inChain[LAST]) begin
          frameCnt <= CNT_W'(1);  // realign: this frame is frame 0
          startQ   <= 1'b1;
        end else begin
          frameCnt <= cntNext;
        end
      end else if (strobe.toggleEdge) begin
        pulseQ   <= (frameCnt == '0);
        startQ   <= (frameCnt == '0);
        frameCnt <= cntNext;
      end
    end
  end

  assign blsOut     = pulseQ;
  assign blockStart = startQ;
endmodule

// File: rtl/blsgen_top.sv
module blsgen_top
  import blsgen_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic       blsIn,
  input  logic       dirOut,
  input  logic       monoMode,
  input  logic       syncPhase,
  input  logic       strapMode,
  input  logic [1:0] strapFmt,
  output logic       blsOut,
  output logic       blsOe,
  output logic       blockStart
);
  blsStrobe_t strobe;

  blsgen_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .dirOut(dirOut),
    .monoMode(monoMode), .syncPhase(syncPhase), .strapMode(strapMode),
    .strapFmt(strapFmt), .strobe(strobe)
  );

  blsgen_datapath #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .blsIn(blsIn), .strobe(strobe),
    .blsOut(blsOut), .blockStart(blockStart)
  );

  assign blsOe = dirOut;
endmodule

// File: rtl/blsgen_chk.sv
module blsgen_chk
  import blsgen_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       dirOut,
  input logic       blsOut,
  input logic       blockStart,
  input blsStrobe_t strobe
);
  // R3 / R8: the start strobe lasts a single cycle
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    blockStart |=> !blockStart);

  // R5: while driven, the marker moves only after a toggle strobe
  p_out_moves_on_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dirOut && $past(dirOut) && (blsOut != $past(blsOut))) |-> $past(strobe.toggleEdge));

  // R2 / R8: a start strobe is always preceded by a frame-sync strobe
  p_start_after_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    blockStart |-> $past(strobe.sampleEdge || strobe.toggleEdge));

  // R1: sampling and toggling never coincide
  p_strobe_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.sampleEdge && strobe.toggleEdge));

  // R1: in input mode no toggle strobe is produced
  p_no_toggle_in_input_r1: assert property (@(posedge clk) disable iff (!rstN)
    !dirOut |-> !strobe.toggleEdge);
endmodule

bind blsgen_top blsgen_chk u_chk (
  .clk(clk), .rstN(rstN), .dirOut(dirOut), .blsOut(blsOut),
  .blockStart(blockStart), .strobe(strobe)
);

// File: tb/sim_blsgen_top.sv
module sim_blsgen_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       strap;
    logic [1:0] fmt;
    logic       ph;
    logic       mono;
    logic       expPh;
    logic [9:0] period;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 10'd192},
    '{1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 10'd192},
    '{1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 10'd384},
    '{1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 10'd192},
    '{1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 10'd384},
    '{1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 10'd192}
  };

  logic clk = 1'b0, rstN = 1'b0, frameSync = 1'b0, blsIn = 1'b0;
  logic dirOut = 1'b0, monoMode = 1'b0, syncPhase = 1'b0, strapMode = 1'b0;
  logic [1:0] strapFmt = 2'b00;
  logic blsOut, blsOe, blockStart;
  int total = 0, bad = 0, pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blsgen_top u0 (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .blsIn(blsIn),
    .dirOut(dirOut), .monoMode(monoMode), .syncPhase(syncPhase),
    .strapMode(strapMode), .strapFmt(strapFmt),
    .blsOut(blsOut), .blsOe(blsOe), .blockStart(blockStart)
  );

  always @(negedge clk) if (rstN && blockStart) pulses++;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; frameSync = 1'b0; blsIn = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    pulses = 0;
  endtask

  // set marker, then move frame sync, then let the change settle
  task automatic halfEdge(input logic lvl, input logic bin);
    blsIn = bin;
    repeat (4) @(negedge clk);
    frameSync = lvl;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state, input direction (R1)
    doReset();
    chk("R1 reset blsOut", blsOut, 0);
    chk("R1 reset blsOe", blsOe, 0);
    chk("R1 reset blockStart", blockStart, 0);

    // input mode, phase 0: marker high at rising edge only (R2, R3)
    halfEdge(1'b1, 1'b1);
    chk("R3 high sample pulses once", pulses, 1);
    halfEdge(1'b0, 1'b0);
    halfEdge(1'b1, 1'b0);
    chk("R3 low sample gives no pulse", pulses, 1);
    halfEdge(1'b0, 1'b1);
    chk("R2 phase0 ignores falling edge", pulses, 1);
    chk("R1 input mode blsOut low", blsOut, 0);
    chk("R1 input mode blsOe low", blsOe, 0);

    // input mode, phase 1 (R2)
    syncPhase = 1'b1;
    halfEdge(1'b1, 1'b1);
    chk("R2 phase1 ignores rising edge", pulses, 1);
    halfEdge(1'b0, 1'b1);
    chk("R2 phase1 samples falling edge", pulses, 2);
    syncPhase = 1'b0;

    // vector table: output mode period and edge (R4 R5 R6 R8)
    for (int v = 0; v < 6; v++) begin
      int act, miss, nFrames;
      doReset();
      strapMode = VECS[v].strap; strapFmt = VECS[v].fmt;
      syncPhase = VECS[v].ph; monoMode = VECS[v].mono; dirOut = 1'b1;
      act = 0; miss = 0;
      nFrames = 2 * int'(VECS[v].period) + 3;
      for (int f = 0; f < nFrames; f++) begin
        for (int h = 0; h < 2; h++) begin
          logic expHi;
          halfEdge(h == 0 ? 1'b1 : 1'b0, 1'b0);
          if ((h == 0) == (VECS[v].expPh == 1'b1)) act++;
          expHi = (act >= 1) && (((act - 1) % int'(VECS[v].period)) == 0);
          if (blsOut !== expHi) miss++;
        end
      end
      if (VECS[v].strap)
        chk($sformatf("R6 strap vector %0d mismatches", v), miss, 0);
      else if (VECS[v].mono)
        chk($sformatf("R4 mono vector %0d mismatches", v), miss, 0);
      else
        chk($sformatf("R5 phase vector %0d mismatches", v), miss, 0);
      chk($sformatf("R8 vector %0d output pulses", v), pulses, 3);
      chk("R1 blsOe follows direction", blsOe, 1);
    end

    // counter realign colliding with wrap (R7)
    strapMode = 1'b0; strapFmt = 2'b00; syncPhase = 1'b0; monoMode = 1'b0;
    dirOut = 1'b0;
    doReset();
    for (int f = 0; f < 191; f++) begin
      halfEdge(1'b1, 1'b0);
      halfEdge(1'b0, 1'b0);
    end
    halfEdge(1'b1, 1'b1);
    chk("R3 start at wrap pulses", pulses, 1);
    dirOut = 1'b1;
    begin
      int miss;
      miss = 0;
      for (int k = 1; k <= 192; k++) begin
        halfEdge(1'b0, 1'b0);
        if (blsOut !== (k == 192)) miss++;
        halfEdge(1'b1, 1'b0);
      end
      chk("R7 realign wins over wrap", miss, 0);
      chk("R8 pulse after realign", pulses, 2);
    end

    // latency (R9)
    doReset();
    dirOut = 1'b1;
    halfEdge(1'b1, 1'b0);
    frameSync = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 not yet after two clocks", blsOut, 0);
    @(negedge clk);
    chk("R9 high after three clocks", blsOut, 1);
    chk("R9 start strobe with output", blockStart, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule